// File: doc/BRIEF.md
# Serial Interrupt Slot Agent

This block is the peripheral end of a shared serial interrupt line. The line is a single wire, pulled high when nobody drives it, and it runs on the same clock as the host. The host opens each cycle by holding the wire low for several clocks. The agent detects the rising edge that ends this pulse and counts three-clock slots from that edge. In the slot that belongs to each of its interrupt sources, it reports the source's level by pulling the wire low. It then drives the wire high for one clock and releases it.

When the sixteen slots are over, the host ends the cycle with a short low pulse. The agent measures the width of that pulse to learn whether the next cycle runs in continuous or quiet mode, and shows the result on `quiet_mode`. The local interrupt levels pass through a two-flop synchronizer. They are frozen when the start pulse ends, so every slot in a cycle reports the same snapshot. Slot 3 is shared by IRQ2 and a system-management request, and the request reaches that slot only when it is enabled. The polarity of IRQ8 can be flipped before it is reported.

Top module: `sirq_slave`

## Requirements
- R1: During reset and in the first cycle after it, `sirq_oe` is 0 and `quiet_mode` is 0, which means continuous mode.
- R2: The agent never drives the wire outside the data slots of a cycle started by the host. When the wire stays high, `sirq_oe` stays 0.
- R3: A cycle starts only when the wire rises after being low for at least 4 consecutive clocks. Start pulses of 4 to 8 clocks are accepted. A low run of 3 clocks or fewer in idle has no effect.
- R4: The first clock in which the wire is seen high after the start pulse is cycle 0. Slot N (N = 1..16) occupies cycles 3N-1, 3N and 3N+1, in the order sample, recovery, turnaround. The agent drives nothing after cycle 49.
- R5: In the sample clock of a slot, `sirq_oe`=1 and `sirq_out`=0 if the level reported for that slot is low. Otherwise `sirq_oe`=0.
- R6: In the recovery clock, `sirq_oe`=1 and `sirq_out`=1 exactly when the agent drove low in the sample clock just before. In the turnaround clock, `sirq_oe`=0.
- R7: Slot 1 is never driven. Slot 2 reports `irq_lvl[1]`. Slot N for N = 4..16 reports `irq_lvl[N-1]`.
- R8: Slot 3 reports low when `irq_lvl[2]` is 0, or when `smi_frame_en`=1 and `smi_n`=0. When `smi_frame_en` is 0, `smi_n` has no effect.
- R9: Slot 9 reports `irq_lvl[8]` XOR `irq8_inv`.
- R10: The levels reported in a cycle are the inputs held steady for the 3 clocks before the start pulse's rising edge. Input changes after that edge do not alter the slots of that cycle.
- R11: After slot 16, a low run of 2 clocks ending in a rising edge sets `quiet_mode` to 1. A run of 3 clocks clears it. Any other width leaves it unchanged. `quiet_mode` changes only in the clock after such a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the host |
| rst_n | input | 1 | Asynchronous reset, active low |
| sirq_in | input | 1 | Observed level of the serial interrupt wire |
| irq_lvl | input | 15 | Interrupt levels, bit n for IRQn (n = 1..15); 0 requests |
| smi_n | input | 1 | System-management request, active low |
| smi_frame_en | input | 1 | Lets the system-management request drive slot 3 |
| irq8_inv | input | 1 | Inverts IRQ8 before it is reported |
| sirq_oe | output | 1 | Drive enable for the wire |
| sirq_out | output | 1 | Value driven when `sirq_oe` is 1 |
| quiet_mode | output | 1 | Mode learned from the last stop pulse; 1 = quiet |

## Verification
On every clock, the bound checker confirms the drive sequence: each low is followed by exactly one high and then a release, and a high is never driven unless the clock before was driven low. It also checks that any drive falls inside slot cycles 2..49 with lows only on sample clocks, that slot 1 stays silent, and that the mode changes only after a stop pulse. The checker cannot judge whether the correct slots are driven. That needs known input vectors, so the bench's scenarios show the slot mapping, the slot-3 sharing, the IRQ8 inversion, the snapshot taken at the start pulse, the rejection of short start pulses and the mode decoding from stop widths.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FRAMES = 2'd1,
    ST_STOP   = 2'd2
  } sirq_state_e;

  typedef enum logic [1:0] {
    PH_SAMPLE  = 2'd0,
    PH_RECOVER = 2'd1,
    PH_TURN    = 2'd2
  } sirq_phase_e;

  // Cycle (counted from the start pulse's rising edge) of slot f's sample clock.
  function automatic int unsigned sample_cycle(int unsigned f);
    return 3 * f - 1;
  endfunction

  // Slot number that owns cycle c (valid for c >= 2).
  function automatic int unsigned slot_frame(int unsigned c);
    return (c + 1) / 3;
  endfunction

  // Phase within the owning slot for cycle c.
  function automatic sirq_phase_e slot_phase(int unsigned c);
    case ((c + 1) % 3)
      0:       return PH_SAMPLE;
      1:       return PH_RECOVER;
      default: return PH_TURN;
    endcase
  endfunction

endpackage

// File: rtl/sirq_sync.sv
module sirq_sync #(
  parameter int W = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/sirq_line_mon.sv
module sirq_line_mon #(
  parameter int RUN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line,
  output logic             rise,
  output logic [RUN_W-1:0] run_len
);
  localparam logic [RUN_W-1:0] RUN_MAX = '1;

  logic prev_line;

  // A rise is a high sample right after a low one; run_len then holds the low width.
  assign rise = !prev_line && line;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_line <= 1'b1;
      run_len   <= '0;
    end else begin
      prev_line <= line;
      if (line)                   run_len <= '0;
      else if (run_len != RUN_MAX) run_len <= run_len + RUN_W'(1);
    end
  end
endmodule

// File: rtl/sirq_report_map.sv
module sirq_report_map #(
  parameter int NFR       = 16,
  parameter int SMI_FRAME = 3,
  parameter int POL_IRQ   = 8
) (
  input  logic [NFR-1:1] irq_lvl,
  input  logic           smi_n,
  input  logic           smi_en,
  input  logic           irq8_inv,
  output logic [NFR-1:0] frame_lvl   // bit f-1 = level reported in slot f
);
  assign frame_lvl[0] = 1'b1;   // slot 1 is reserved and never pulled low

  for (genvar f = 2; f <= NFR; f++) begin : g_slot
    if (f == SMI_FRAME) begin : g_shared
      assign frame_lvl[f-1] = irq_lvl[f-1] & ~(smi_en & ~smi_n);
    end else if ((f - 1) == POL_IRQ) begin : g_pol
      assign frame_lvl[f-1] = irq_lvl[f-1] ^ irq8_inv;
    end else begin : g_plain
      assign frame_lvl[f-1] = irq_lvl[f-1];
    end
  end
endmodule

// File: rtl/sirq_slot_drv.sv
module sirq_slot_drv
  import sirq_pkg::*;
#(
  parameter int NFR = 16,
  parameter int CW  = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           slot_en,    // next clock belongs to the data slots
  input  logic [CW-1:0]  nxt_idx,    // cycle index of the next clock
  input  logic [NFR-1:0] lvl,        // frozen per-slot levels
  output logic           sirq_oe,
  output logic           sirq_out
);
  localparam int unsigned FIRST_CYC = sample_cycle(1);
  localparam int unsigned LAST_CYC  = sample_cycle(NFR) + 2;
  localparam int FW = (NFR > 1) ? $clog2(NFR) : 1;

  int unsigned  ni;
  logic         in_range;
  sirq_phase_e  ph;
  logic [FW-1:0] fsel;
  logic         oe_d, out_d;

  always_comb begin
    ni       = 32'(nxt_idx);
    in_range = slot_en && (ni >= FIRST_CYC) && (ni <= LAST_CYC);
    ph       = slot_phase(ni);
    fsel     = in_range ? FW'(slot_frame(ni) - 1) : '0;
    oe_d     = 1'b0;
    out_d    = 1'b1;
    if (in_range) begin
      case (ph)
        PH_SAMPLE: begin
          oe_d  = !lvl[fsel];
          out_d = 1'b0;
        end
        PH_RECOVER: begin
          oe_d  = sirq_oe && !sirq_out;   // restore only what this agent pulled low
          out_d = 1'b1;
        end
        default: begin
          oe_d  = 1'b0;
          out_d = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sirq_oe  <= 1'b0;
      sirq_out <= 1'b1;
    end else begin
      sirq_oe  <= oe_d;
      sirq_out <= out_d;
    end
  end
endmodule

// File: rtl/sirq_slave.sv
module sirq_slave
  import sirq_pkg::*;
#(
  parameter int NFR        = 16,
  parameter int START_MIN  = 4,
  parameter int QUIET_STOP = 2,
  parameter int CONT_STOP  = 3,
  parameter int RUN_W      = 4,
  parameter int SMI_FRAME  = 3,
  parameter int POL_IRQ    = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sirq_in,
  input  logic [NFR-1:1] irq_lvl,
  input  logic           smi_n,
  input  logic           smi_frame_en,
  input  logic           irq8_inv,
  output logic           sirq_oe,
  output logic           sirq_out,
  output logic           quiet_mode
);
  localparam int unsigned LAST_CYC = sample_cycle(NFR) + 2;
  localparam int CW = $clog2(LAST_CYC + 1);
  localparam int SW = NFR + 2;
  localparam logic [SW-1:0] SYNC_RST = {1'b0, 1'b0, 1'b1, {(NFR-1){1'b1}}};

  sirq_state_e    state;
  logic [CW-1:0]  cyc_idx;
  logic [CW-1:0]  nxt_idx;
  logic [NFR-1:0] frame_lvl, snap;
  logic           rise;
  logic [RUN_W-1:0] run_len;

  // Named internal events, also observed by the bound checker.
  logic start_go, stop_done, frames_end, in_frames, slot_en;

  logic [NFR-1:1] irq_s;
  logic           smi_n_s, smi_en_s, inv_s;

  sirq_sync #(.W(SW), .RST_VAL(SYNC_RST)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({irq8_inv, smi_frame_en, smi_n, irq_lvl}),
    .q     ({inv_s, smi_en_s, smi_n_s, irq_s})
  );

  sirq_line_mon #(.RUN_W(RUN_W)) u_mon (
    .clk     (clk),
    .rst_n   (rst_n),
    .line    (sirq_in),
    .rise    (rise),
    .run_len (run_len)
  );

  sirq_report_map #(.NFR(NFR), .SMI_FRAME(SMI_FRAME), .POL_IRQ(POL_IRQ)) u_map (
    .irq_lvl   (irq_s),
    .smi_n     (smi_n_s),
    .smi_en    (smi_en_s),
    .irq8_inv  (inv_s),
    .frame_lvl (frame_lvl)
  );

  assign in_frames  = (state == ST_FRAMES);
  assign start_go   = (state == ST_IDLE) && rise && (run_len >= RUN_W'(START_MIN));
  assign stop_done  = (state == ST_STOP) && rise;
  assign frames_end = in_frames && (cyc_idx == CW'(LAST_CYC));
  assign slot_en    = start_go || (in_frames && !frames_end);
  assign nxt_idx    = start_go ? CW'(1) : cyc_idx + CW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cyc_idx    <= '0;
      snap       <= '1;
      quiet_mode <= 1'b0;
    end else begin
      case (state)
        ST_IDLE:   if (start_go)   state <= ST_FRAMES;
        ST_FRAMES: if (frames_end) state <= ST_STOP;
        ST_STOP:   if (stop_done)  state <= ST_IDLE;
        default:                   state <= ST_IDLE;
      endcase
      cyc_idx <= slot_en ? nxt_idx : '0;
      if (start_go) snap <= frame_lvl;
      if (stop_done) begin
        if (run_len == RUN_W'(QUIET_STOP))     quiet_mode <= 1'b1;
        else if (run_len == RUN_W'(CONT_STOP)) quiet_mode <= 1'b0;
      end
    end
  end

  sirq_slot_drv #(.NFR(NFR), .CW(CW)) u_drv (
    .clk      (clk),
    .rst_n    (rst_n),
    .slot_en  (slot_en),
    .nxt_idx  (nxt_idx),
    .lvl      (snap),
    .sirq_oe  (sirq_oe),
    .sirq_out (sirq_out)
  );
endmodule

// File: rtl/sirq_slave_chk.sv
module sirq_slave_chk #(
  parameter int NFR = 16
) (
  input logic clk,
  input logic rst_n,
  input logic sirq_oe,
  input logic sirq_out,
  input logic quiet_mode,
  input logic in_frames,
  input logic [$clog2(3*NFR+2)-1:0] cyc_idx,
  input logic stop_done
);
  localparam int LAST_CYC = 3 * NFR + 1;
  localparam int CW = $clog2(3 * NFR + 2);

  AST_RESET_RELEASES: assert property (@(posedge clk)
    !rst_n |=> !sirq_oe); // R1

  AST_DRIVE_IN_SLOTS: assert property (@(posedge clk) disable iff (!rst_n)
    sirq_oe |-> (in_frames && cyc_idx >= CW'(2) && cyc_idx <= CW'(LAST_CYC))); // R4

  AST_LOW_ON_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    (sirq_oe && !sirq_out) |-> ((32'(cyc_idx) % 3) == 2)); // R5

  AST_LOW_THEN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (sirq_oe && !sirq_out) |=> (sirq_oe && sirq_out)); // R6

  AST_HIGH_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (sirq_oe && sirq_out) |-> $past(sirq_oe && !sirq_out)); // R6

  AST_HIGH_THEN_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (sirq_oe && sirq_out) |=> !sirq_oe); // R6

  AST_SLOT1_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_frames && cyc_idx == CW'(2)) |-> !sirq_oe); // R7

  AST_MODE_AT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet_mode != $past(quiet_mode)) |-> $past(stop_done)); // R11
endmodule

bind sirq_slave sirq_slave_chk #(.NFR(NFR)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sirq_oe    (sirq_oe),
  .sirq_out   (sirq_out),
  .quiet_mode (quiet_mode),
  .in_frames  (in_frames),
  .cyc_idx    (cyc_idx),
  .stop_done  (stop_done)
);

// File: tb/tb_sirq_slave.sv
`timescale 1ns/1ps
module tb_sirq_slave;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_low = 1'b0;
  logic [15:1] irq_lvl = '1;
  logic smi_n = 1'b1, smi_frame_en = 1'b0, irq8_inv = 1'b0;
  logic sirq_oe, sirq_out, quiet_mode;
  wire  sirq_line = host_low ? 1'b0 : (sirq_oe ? sirq_out : 1'b1);

  int checks = 0, fails = 0;
  bit done = 0;
  bit exp_quiet = 0;
  // snapshot the bench expects the agent to report
  logic [15:1] s_lv;
  bit s_smi_n, s_en, s_inv;

  always #5 clk = ~clk;

  sirq_slave dut (
    .clk(clk), .rst_n(rst_n), .sirq_in(sirq_line), .irq_lvl(irq_lvl),
    .smi_n(smi_n), .smi_frame_en(smi_frame_en), .irq8_inv(irq8_inv),
    .sirq_oe(sirq_oe), .sirq_out(sirq_out), .quiet_mode(quiet_mode)
  );

  task automatic chk(string req, string what, logic act, logic expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s %s at %0t: actual=%b expected=%b", req, what, $time, act, expv);
    end
  endtask

  // One bench interval: checks the outputs of this clock, then drives the host side.
  task automatic step(bit hl, string req, bit e_oe, bit e_out);
    chk(req, "sirq_oe", sirq_oe, e_oe);
    if (e_oe) chk(req, "sirq_out", sirq_out, e_out);
    chk((req == "R1") ? "R1" : "R11", "quiet_mode", quiet_mode, exp_quiet);
    host_low = hl;
    @(negedge clk);
  endtask

  // Whether slot f should be pulled low for the frozen snapshot.
  function automatic bit want_low(int f);
    if (f == 1) return 0;
    if (f == 3) return (s_lv[2] == 1'b0) || (s_en && !s_smi_n);
    if (f == 9) return (s_lv[8] ^ s_inv) == 1'b0;
    return s_lv[f-1] == 1'b0;
  endfunction

  function automatic string tag_for(int f, int ph, bit changed);
    if (f == 1) return "R7";
    if (changed) return "R10";
    if (f == 3) return "R8";
    if (f == 9) return "R9";
    if (ph == 0) return "R4 R5";
    return "R6";
  endfunction

  task automatic run_cycle(logic [15:1] lv, bit smn, bit sen, bit inv,
                           int start_len, int stop_len, bit chg, logic [15:1] lv2);
    bit changed = 0;
    irq_lvl = lv; smi_n = smn; smi_frame_en = sen; irq8_inv = inv;
    s_lv = lv; s_smi_n = smn; s_en = sen; s_inv = inv;
    for (int i = 0; i < 3; i++) step(0, "R2", 0, 1);
    for (int i = 0; i < start_len; i++) step(1, "R3", 0, 1);
    for (int k = 0; k <= 49; k++) begin
      if (chg && k == 10) begin
        irq_lvl = lv2; smi_n = 1'b0; changed = 1;
      end
      if (k < 2) step(0, "R4", 0, 1);
      else begin
        int f = (k + 1) / 3;
        int ph = k - (3 * f - 1);
        bit d = want_low(f);
        if (ph == 0)      step(0, tag_for(f, ph, changed), d, 0);
        else if (ph == 1) step(0, tag_for(f, ph, changed), d, 1);
        else              step(0, "R6", 0, 1);
      end
    end
    for (int i = 0; i < stop_len; i++) step(1, "R4", 0, 1);
    step(0, "R11", 0, 1);                 // rising edge that ends the stop pulse
    if (stop_len == 2) exp_quiet = 1;
    else if (stop_len == 3) exp_quiet = 0;
    step(0, "R11", 0, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R2 watchdog: actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:1] v;
    @(negedge clk);
    for (int i = 0; i < 4; i++) step(0, "R1", 0, 1);
    rst_n = 1'b1;
    step(0, "R1", 0, 1);
    // idle line in continuous mode: the agent must never start anything
    for (int i = 0; i < 20; i++) step(0, "R2", 0, 1);

    // nothing pending; stop of 3 keeps continuous mode
    run_cycle('1, 1, 1, 0, 4, 3, 0, '1);

    // IRQ1, IRQ5, IRQ13, IRQ15 low; SMI requested but not enabled; stop of 2 -> quiet
    v = '1; v[1] = 0; v[5] = 0; v[13] = 0; v[15] = 0;
    run_cycle(v, 0, 0, 0, 5, 2, 0, '1);

    // SMI enabled onto slot 3, IRQ8 high but inverted, IRQ3 low, 8-clock start,
    // inputs all dropped mid-cycle; stop of 5 leaves quiet mode set
    v = '1; v[3] = 0;
    run_cycle(v, 0, 1, 1, 8, 5, 1, '0);

    // everything low, IRQ8 inverted so slot 9 stays silent; IRQ2 alone drives slot 3
    run_cycle('0, 1, 0, 1, 4, 3, 0, '0);

    // short low pulse in idle with requests pending: no cycle may start
    irq_lvl = '0;
    for (int i = 0; i < 4; i++) step(0, "R3", 0, 1);
    for (int i = 0; i < 3; i++) step(1, "R3", 0, 1);
    for (int i = 0; i < 60; i++) step(0, "R3", 0, 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule